// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block handles core-to-core software interrupts inside a multi-core interrupt distributor. It serves up to 8 cores and 16 interrupt IDs. A core issues a 32-bit command word over the register bus. The block decodes three things from it: the interrupt ID, a list of receiving cores, and a filter mode. For every receiving core, it records the sending core as one bit in an 8-bit source mask. There is one mask for each (receiver, ID) pair. A (receiver, ID) pair is pending whenever its mask holds any bit.

Software can also see and change the masks directly through two windows on the same bus. A set window ORs bits in and a clear window removes them. Both windows pack four IDs into each 32-bit word. A drain port hands the recorded sources of one pair to the delivery side, one per cycle, lowest core number first. The pair stays pending until its last source has been retired.

Top module: `sgi_dispatch`

## Requirements
- R1: A synchronous active-high reset empties every source mask. After reset, `pending`, `maskUpdated` and `busRvalid` are all 0.
- R2: A write with `busKind`=0 is a command. The interrupt ID is in bits [3:0], the core list in bits [23:16] and the filter mode in bits [25:24]. In mode 0 the list is ANDed with the online set, which is cores 0 to `onlineCount`-1. If the result is empty, the command changes nothing.
- R3: In mode 1 the command goes to every online core except the writer (`busCore`).
- R4: In mode 2 the command goes only to the writer.
- R5: Mode 3 behaves exactly like mode 0.
- R6: For each receiving core, bit `busCore` of that core's mask for the ID becomes 1, and the pair's bit in `pending` rises. Bit c*16+id of `pending` equals OR of the mask of core c and ID id.
- R7: `busRdata` is valid with `busRvalid`, one cycle after a read. A read with `busKind` 0 (command) or 3 (unused) returns zero. A write with `busKind` 3 changes nothing.
- R8: `busKind` 1 is the set window and `busKind` 2 is the clear window. In both, byte n of word `busWord`=w holds the mask of ID 4w+n for core `busCore`. Both windows read the same data.
- R9: A set-window write ORs each byte into its mask. A clear-window write clears the mask bits that are 1 in the written byte.
- R10: While `drainValid` selects a pair whose mask is non-zero, `drainHit` is 1 in the same cycle and `drainSrc` is the lowest set bit. That bit is cleared at the clock edge. `pending` falls only when the last bit has been drained. With no bus access and no drain, `pending` does not change.
- R11: `maskUpdated` is 1 for exactly the cycle after a set or clear write that changes at least one mask bit. A write that changes no bit leaves it at 0.
- R12: A drain and a command or window write on the same pair in the same cycle take effect together. The drained bit is cleared first, then the new bits are ORed in. A command from the drained source therefore leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| onlineCount | input | 4 | Number of online cores (0..8) |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busKind | input | 2 | 0 command, 1 set window, 2 clear window, 3 unused |
| busWord | input | 2 | Window word index (IDs 4w..4w+3) |
| busCore | input | 3 | Core making the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| busRvalid | output | 1 | Read data valid |
| drainValid | input | 1 | Drain request |
| drainCore | input | 3 | Receiving core to drain |
| drainId | input | 4 | Interrupt ID to drain |
| drainHit | output | 1 | Selected mask is non-zero |
| drainSrc | output | 3 | Source retired this cycle |
| pending | output | 128 | Pending flag per (core, ID), index core*16+id |
| maskUpdated | output | 1 | One-cycle pulse after a mask-changing window write |

## Verification
The drain port and the register bus are independent, so a source can be retired in the same cycle in which a command or window write targets the same pair. The bench drives both on one clock edge, in two cases. In the first, the dispatched sender equals the drained bit. In the second, it does not. The result is judged by reading the mask back through the clear window and checking the `pending` bit. This shows whether the clear-then-OR ordering of R12 holds and whether a drained-then-redispatched source survives.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int MASK_W     = 8;
  localparam int ID_W       = 4;
  localparam int CORE_W     = 3;
  localparam int WORD_IDX_W = 2;
  localparam int DATA_W     = 32;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_NONE = 2'd3
  } busKind_e;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filter_e;

  typedef struct packed {
    logic                  dispEn;
    logic [MASK_W-1:0]     dispTargets;
    logic [ID_W-1:0]       dispId;
    logic [CORE_W-1:0]     srcCore;
    logic                  setEn;
    logic                  clrEn;
    logic                  rdEn;
    logic                  rdZero;
    logic [CORE_W-1:0]     accCore;
    logic [WORD_IDX_W-1:0] wordIdx;
    logic [DATA_W-1:0]     wBytes;
    logic                  drainEn;
    logic [CORE_W-1:0]     drainCore;
    logic [ID_W-1:0]       drainId;
  } ctlStrobes_t;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int NUM_IDS   = 16
) (
  input  logic [3:0]            onlineCount,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [1:0]            busKind,
  input  logic [WORD_IDX_W-1:0] busWord,
  input  logic [CORE_W-1:0]     busCore,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  drainValid,
  input  logic [CORE_W-1:0]     drainCore,
  input  logic [ID_W-1:0]       drainId,
  output ctlStrobes_t           ctl
);
  busKind_e          kind;
  filter_e           filt;
  logic [MASK_W-1:0] onlineMask;
  logic [MASK_W-1:0] selfMask;
  logic [MASK_W-1:0] targets;

  always_comb begin
    kind     = busKind_e'(busKind);
    filt     = filter_e'(busWdata[25:24]);
    selfMask = MASK_W'(1) << busCore;
    for (int k = 0; k < MASK_W; k++) begin
      onlineMask[k] = (k < NUM_CORES) && (k < int'(onlineCount));
    end
    unique case (filt)
      FLT_OTHERS: targets = onlineMask & ~selfMask;
      FLT_SELF:   targets = selfMask;
      default:    targets = busWdata[23:16] & onlineMask;
    endcase

    ctl             = '0;
    ctl.dispEn      = busValid && busWrite && (kind == KIND_CMD) && (targets != '0);
    ctl.dispTargets = targets;
    ctl.dispId      = busWdata[ID_W-1:0];
    ctl.srcCore     = busCore;
    ctl.setEn       = busValid && busWrite && (kind == KIND_SET);
    ctl.clrEn       = busValid && busWrite && (kind == KIND_CLR);
    ctl.rdEn        = busValid && !busWrite;
    ctl.rdZero      = (kind == KIND_CMD) || (kind == KIND_NONE);
    ctl.accCore     = busCore;
    ctl.wordIdx     = busWord;
    ctl.wBytes      = busWdata;
    ctl.drainEn     = drainValid && (int'(drainCore) < NUM_CORES) && (int'(drainId) < NUM_IDS);
    ctl.drainCore   = drainCore;
    ctl.drainId     = drainId;
  end
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int NUM_IDS   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctlStrobes_t                ctl,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid,
  output logic                       drainHit,
  output logic [CORE_W-1:0]          drainSrc,
  output logic [NUM_CORES*NUM_IDS-1:0] pendVec,
  output logic                       updPulse
);
  localparam int CELLS = NUM_CORES * NUM_IDS;

  logic [CELLS*MASK_W-1:0] maskFlat;
  logic [CELLS-1:0]        changeVec;
  logic [MASK_W-1:0]       selMask;
  logic [DATA_W-1:0]       rdNext;

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    for (genvar i = 0; i < NUM_IDS; i++) begin : gId
      localparam int IDX = c * NUM_IDS + i;
      logic [MASK_W-1:0] cellQ, dispBits, setBits, clrBits, drainBits, wrView;
      logic hereDrain, hereWr;

      always_comb begin
        hereDrain = ctl.drainEn && (ctl.drainCore == CORE_W'(c)) && (ctl.drainId == ID_W'(i));
        hereWr    = (ctl.accCore == CORE_W'(c)) && (ctl.wordIdx == WORD_IDX_W'(i / 4));
        dispBits  = (ctl.dispEn && ctl.dispTargets[c] && (ctl.dispId == ID_W'(i)))
                    ? (MASK_W'(1) << ctl.srcCore) : '0;
        setBits   = (ctl.setEn && hereWr) ? ctl.wBytes[MASK_W*(i%4) +: MASK_W] : '0;
        clrBits   = (ctl.clrEn && hereWr) ? ctl.wBytes[MASK_W*(i%4) +: MASK_W] : '0;
        drainBits = hereDrain ? (cellQ & (~cellQ + MASK_W'(1))) : '0;
        wrView    = (cellQ | setBits) & ~clrBits;
      end

      always_ff @(posedge clk) begin
        if (rst) cellQ <= '0;
        else     cellQ <= ((cellQ & ~drainBits) | dispBits | setBits) & ~clrBits;
      end

      assign maskFlat[IDX*MASK_W +: MASK_W] = cellQ;
      assign changeVec[IDX] = (wrView != cellQ);
      assign pendVec[IDX]   = |cellQ;
    end
  end

  always_comb begin
    selMask = '0;
    rdNext  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int i = 0; i < NUM_IDS; i++) begin
        if (ctl.drainCore == CORE_W'(c) && ctl.drainId == ID_W'(i))
          selMask = maskFlat[(c*NUM_IDS+i)*MASK_W +: MASK_W];
        if (ctl.accCore == CORE_W'(c) && ctl.wordIdx == WORD_IDX_W'(i / 4))
          rdNext[MASK_W*(i%4) +: MASK_W] = maskFlat[(c*NUM_IDS+i)*MASK_W +: MASK_W];
      end
    end
    if (!ctl.drainEn) selMask = '0;
    if (ctl.rdZero)   rdNext  = '0;
    drainHit = |selMask;
    drainSrc = '0;
    for (int k = MASK_W - 1; k >= 0; k--) begin
      if (selMask[k]) drainSrc = CORE_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      updPulse <= 1'b0;
    end else begin
      rdValid  <= ctl.rdEn;
      updPulse <= (ctl.setEn || ctl.clrEn) && (|changeVec);
      if (ctl.rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int NUM_IDS   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [3:0]                   onlineCount,
  input  logic                         busValid,
  input  logic                         busWrite,
  input  logic [1:0]                   busKind,
  input  logic [1:0]                   busWord,
  input  logic [2:0]                   busCore,
  input  logic [31:0]                  busWdata,
  output logic [31:0]                  busRdata,
  output logic                         busRvalid,
  input  logic                         drainValid,
  input  logic [2:0]                   drainCore,
  input  logic [3:0]                   drainId,
  output logic                         drainHit,
  output logic [2:0]                   drainSrc,
  output logic [NUM_CORES*NUM_IDS-1:0] pending,
  output logic                         maskUpdated
);
  ctlStrobes_t ctl;

  sgi_ctrl #(.NUM_CORES(NUM_CORES), .NUM_IDS(NUM_IDS)) uCtrl (
    .onlineCount(onlineCount), .busValid(busValid), .busWrite(busWrite),
    .busKind(busKind), .busWord(busWord), .busCore(busCore), .busWdata(busWdata),
    .drainValid(drainValid), .drainCore(drainCore), .drainId(drainId), .ctl(ctl)
  );

  sgi_datapath #(.NUM_CORES(NUM_CORES), .NUM_IDS(NUM_IDS)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .rdData(busRdata), .rdValid(busRvalid),
    .drainHit(drainHit), .drainSrc(drainSrc), .pendVec(pending), .updPulse(maskUpdated)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CORES = 8,
  parameter int NUM_IDS   = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         busValid,
  input logic                         busWrite,
  input logic [1:0]                   busKind,
  input logic [31:0]                  busRdata,
  input logic                         busRvalid,
  input logic                         drainValid,
  input logic [2:0]                   drainCore,
  input logic [3:0]                   drainId,
  input logic                         drainHit,
  input logic [NUM_CORES*NUM_IDS-1:0] pending,
  input logic                         maskUpdated
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pending == '0 && !maskUpdated && !busRvalid));

  // R11
  upd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    maskUpdated |-> $past(busValid && busWrite && (busKind == 2'd1 || busKind == 2'd2)));

  // R7
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    busRvalid |-> $past(busValid && !busWrite));

  // R7
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (busRvalid && $past(busKind == 2'd0 || busKind == 2'd3)) |-> (busRdata == 32'd0));

  // R10
  drain_req_chk: assert property (@(posedge clk) disable iff (rst)
    !drainValid |-> !drainHit);

  // R10
  drain_pending_chk: assert property (@(posedge clk) disable iff (rst)
    drainHit |-> pending[int'(drainCore)*NUM_IDS + int'(drainId)]);

  // R10
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!busValid && !drainValid) |-> $stable(pending));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CORES(NUM_CORES), .NUM_IDS(NUM_IDS)) uChk (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busKind(busKind),
  .busRdata(busRdata), .busRvalid(busRvalid), .drainValid(drainValid),
  .drainCore(drainCore), .drainId(drainId), .drainHit(drainHit),
  .pending(pending), .maskUpdated(maskUpdated)
);

// File: tb/sim_sgi_dispatch.sv
`timescale 1ns/1ps
module sim_sgi_dispatch;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   onlineCount = 4'd8;
  logic         busValid = 0, busWrite = 0;
  logic [1:0]   busKind = 0, busWord = 0;
  logic [2:0]   busCore = 0;
  logic [31:0]  busWdata = 0;
  logic [31:0]  busRdata;
  logic         busRvalid;
  logic         drainValid = 0;
  logic [2:0]   drainCore = 0;
  logic [3:0]   drainId = 0;
  logic         drainHit;
  logic [2:0]   drainSrc;
  logic [127:0] pending;
  logic         maskUpdated;

  int nChecks = 0, nFail = 0, cycles = 0;
  logic [7:0] m [8][16];

  always #10 clk = ~clk;

  sgi_dispatch u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expPend();
    logic [127:0] v = '0;
    for (int c = 0; c < 8; c++) for (int i = 0; i < 16; i++) v[c*16+i] = |m[c][i];
    return v;
  endfunction

  function automatic logic [7:0] targetsOf(input int mode, input int lst, input int wr, input int onl);
    int om = (1 << onl) - 1;
    if (mode == 1) return 8'(om & ~(1 << wr));
    if (mode == 2) return 8'(1 << wr);
    return 8'(lst & om);
  endfunction

  task automatic busOp(input logic wr, input int kind, input int core, input int word, input logic [31:0] d);
    busValid = 1; busWrite = wr; busKind = 2'(kind); busCore = 3'(core);
    busWord = 2'(word); busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic sendCmd(input int wr, input int mode, input int lst, input int id);
    logic [7:0] t = targetsOf(mode, lst, wr, int'(onlineCount));
    for (int c = 0; c < 8; c++) if (t[c]) m[c][id] |= 8'(1 << wr);
    busOp(1, 0, wr, 0, {6'd0, 2'(mode), 8'(lst), 12'd0, 4'(id)});
  endtask

  task automatic readAll(input string tag, input int kind);
    for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) begin
      busOp(0, kind, c, w, 32'hDEAD_BEEF);
      chk(tag, {96'd0, busRdata}, {96'd0, m[c][4*w+3], m[c][4*w+2], m[c][4*w+1], m[c][4*w]});
    end
  endtask

  task automatic clearAll();
    for (int c = 0; c < 8; c++) for (int w = 0; w < 4; w++) busOp(1, 2, c, w, 32'hFFFF_FFFF);
    for (int c = 0; c < 8; c++) for (int i = 0; i < 16; i++) m[c][i] = 8'd0;
  endtask

  task automatic drainChk(input string tag, input int c, input int id);
    int low = -1;
    for (int k = 7; k >= 0; k--) if (m[c][id][k]) low = k;
    drainValid = 1; drainCore = 3'(c); drainId = 4'(id);
    #1;
    chk(tag, {127'd0, drainHit}, {127'd0, low >= 0});
    if (low >= 0) begin
      chk(tag, {125'd0, drainSrc}, 128'(low));
      m[c][id][low] = 1'b0;
    end
    @(negedge clk);
    drainValid = 0;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) for (int i = 0; i < 16; i++) m[c][i] = 8'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 pending", pending, 128'd0);
    chk("R1 upd", {127'd0, maskUpdated}, 128'd0);
    readAll("R1 readback", 1);

    // R2 R3 R4 R5 R6: sweep modes and writers, all cores online
    for (int mode = 0; mode < 4; mode++) begin
      for (int wr = 0; wr < 8; wr++) begin
        sendCmd(wr, mode, (8'h5A ^ (wr * 37)) & 8'hFF, (wr + mode * 3) % 16);
        chk($sformatf("R6 pending mode%0d wr%0d (R2 R3 R4 R5)", mode, wr), pending, expPend());
      end
    end
    readAll("R6 sweep readback", 1);
    readAll("R8 clear-window readback", 2);

    // R7: command and unused kind read zero, unused write ignored
    busOp(0, 0, 3, 1, 0);
    chk("R7 cmd read", {96'd0, busRdata}, 128'd0);
    busOp(0, 3, 3, 1, 0);
    chk("R7 unused read", {96'd0, busRdata}, 128'd0);
    busOp(1, 3, 0, 0, 32'hFFFF_FFFF);
    chk("R7 unused write", pending, expPend());

    clearAll();
    @(negedge clk);
    chk("R9 clear all", pending, 128'd0);

    // R2: partial online set and no-op commands
    onlineCount = 4'd5;
    sendCmd(2, 1, 0, 9);
    chk("R3 online5", pending, expPend());
    sendCmd(4, 0, 8'hFF, 10);
    chk("R2 online5 list", pending, expPend());
    sendCmd(1, 0, 8'h00, 11);
    chk("R2 empty list", pending, expPend());
    sendCmd(1, 0, 8'hE0, 12);
    chk("R2 offline list", pending, expPend());
    sendCmd(3, 3, 8'h21, 13);
    chk("R5 reserved mode", pending, expPend());
    sendCmd(4, 2, 8'hFF, 14);
    chk("R4 self", pending, expPend());
    readAll("R2 online5 readback", 1);
    onlineCount = 4'd8;
    clearAll();

    // R8 R9 R11: window layout, set/clear, update pulse
    busOp(1, 1, 6, 3, 32'h8040_2010);
    m[6][12] = 8'h10; m[6][13] = 8'h20; m[6][14] = 8'h40; m[6][15] = 8'h80;
    chk("R11 set changes", {127'd0, maskUpdated}, 128'd1);
    chk("R8 pending bits", pending, expPend());
    busOp(1, 1, 6, 3, 32'h8040_2010);
    chk("R11 set no change", {127'd0, maskUpdated}, 128'd0);
    busOp(1, 2, 6, 3, 32'h00C0_0030);
    m[6][12] = 8'h10 & ~8'h30; m[6][14] = 8'h40 & ~8'hC0;
    chk("R11 clear changes", {127'd0, maskUpdated}, 128'd1);
    @(negedge clk);
    chk("R11 pulse one cycle", {127'd0, maskUpdated}, 128'd0);
    busOp(0, 2, 6, 3, 0);
    chk("R9 clear result", {96'd0, busRdata}, {96'd0, m[6][15], m[6][14], m[6][13], m[6][12]});
    chk("R9 pending", pending, expPend());

    // R10: drain walks sources lowest first
    busOp(1, 1, 1, 1, 32'h0000_A400);
    m[1][5] = 8'hA4;
    for (int k = 0; k < 3; k++) begin
      drainChk("R10 drain step", 1, 5);
      chk("R10 pending during drain", pending, expPend());
    end
    drainChk("R10 drain empty", 1, 5);

    // R12: drain and dispatch on the same pair in the same cycle
    busOp(1, 1, 0, 0, 32'h0000_0001);
    m[0][0] = 8'h01;
    busValid = 1; busWrite = 1; busKind = 0; busCore = 0; busWdata = {6'd0, 2'd2, 8'd0, 16'd0};
    drainChk("R12 drain same src", 0, 0);
    busValid = 0; busWrite = 0;
    m[0][0] |= 8'h01;
    busOp(0, 2, 0, 0, 0);
    chk("R12 same sender survives", {96'd0, busRdata}, {96'd0, m[0][3], m[0][2], m[0][1], m[0][0]});
    busValid = 1; busWrite = 1; busKind = 0; busCore = 3; busWdata = {6'd0, 2'd0, 8'h01, 16'd0};
    drainChk("R12 drain other src", 0, 0);
    busValid = 0; busWrite = 0;
    m[0][0] |= 8'h08;
    busOp(0, 2, 0, 0, 0);
    chk("R12 other sender", {96'd0, busRdata}, {96'd0, m[0][3], m[0][2], m[0][1], m[0][0]});
    chk("R12 pending", pending, expPend());

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected<50000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule